// File: doc/BRIEF.md
# Interrupt Destination Resolver with Rotating Lowest-Priority Pick

This block sits between a bank of interrupt input lines and the fabric that carries interrupt messages to processors. Every line has a routing entry, supplied as a flat input vector. The entry holds the vector, the delivery mode, how the destination is read, polarity, trigger mode, a mask bit and an 8-bit destination. When a line rises and its entry is unmasked, the block builds one message. It also works out an M-bit mask that marks which processors the message must reach.

Each processor's logical-destination byte arrives on an input. The resolver compares these bytes with the entry's destination to find logical targets. In physical mode the destination is read directly as a processor index, or as a broadcast. For lowest-priority delivery, processor priority is not used. The block keeps exactly one of the logically matched processors, selected by a free-running rotation count taken modulo the number of matches. For external-interrupt delivery, the vector comes from a legacy controller input and not from the entry. Messages leave through a valid/ready handshake.

Top module: `irq_route_resolver`

## Requirements
- R1: A line is signalled only on a low-to-high change of its pin. A pin held high does not signal again. Lowering a pin only re-arms it.
- R2: When the entry mask bit (bit 14) is set at service time, the event is dropped: no message and no error.
- R3: In physical destination mode (entry bit 11 = 0), destination 0xFF sets every target bit. A destination below M sets only that processor's bit. Any other value gives an empty mask, and the message is still emitted.
- R4: In logical mode (bit 11 = 1), processor k is a target when the destination byte ANDed with processor k's logical byte is nonzero.
- R5: Lowest-priority delivery (mode 001) in logical mode keeps only the match whose ascending position equals the rotation count modulo the match count. The count advances once per such selection, and only reset clears it. When there are no matches, the message carries an empty mask and the count does not move.
- R6: Lowest-priority delivery in physical mode pulses cfg_error for one cycle and emits no message.
- R7: With mode 111 (external interrupt), msg_vector equals ext_vector. Otherwise it equals entry bits 7:0.
- R8: The message copies the destination (entry bits 23:16), the mode (bits 10:8) and the destination mode (bit 11). msg_level copies polarity (bit 12) and msg_trigger copies trigger (bit 13).
- R9: Lines that rise in the same cycle are held pending and serviced one per cycle, lowest line index first.
- R10: While msg_valid is high and msg_ready is low, the message and its targets stay unchanged.
- R11: After reset, msg_valid and cfg_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pins | input | N | Interrupt input lines |
| route_tbl | input | N*24 | Routing entries, line i at bits i*24+23 : i*24 |
| ldr_bytes | input | M*8 | Logical-destination byte of each processor |
| ext_vector | input | 8 | Vector from the legacy controller |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Destination field |
| msg_vector | output | 8 | Vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | 0 physical, 1 logical |
| msg_level | output | 1 | Copied polarity |
| msg_trigger | output | 1 | Copied trigger mode |
| msg_targets | output | M | Target processor mask |
| cfg_error | output | 1 | One-cycle pulse on an illegal mode combination |

## Verification
Two things can happen in the same cycle. A pending line can be cleared by the service logic while new edges are captured into the pending mask, and the service itself can stall behind a held message. The bench raises several lines together while msg_ready is low. It then checks that the held message does not change and that the remaining lines come out in ascending order. A constrained-random stream of single-line events, with a mix of modes, masks and logical bytes, is compared against a bench model. That model also tracks the rotation count, so a missed or extra advance would change every later lowest-priority pick.

// File: rtl/irq_route_resolver.sv
module irq_route_resolver #(
  parameter int N     = 8,
  parameter int M     = 4,
  parameter int ROT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_pins,
  input  logic [N*24-1:0] route_tbl,
  input  logic [M*8-1:0] ldr_bytes,
  input  logic [7:0]     ext_vector,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [7:0]     msg_dest,
  output logic [7:0]     msg_vector,
  output logic [2:0]     msg_dmode,
  output logic           msg_destmode,
  output logic           msg_level,
  output logic           msg_trigger,
  output logic [M-1:0]   msg_targets,
  output logic           cfg_error
);
  localparam int EW = 24;
  localparam int CW = $clog2(M + 1);
  localparam logic [2:0] MODE_LOWPRI = 3'b001;
  localparam logic [2:0] MODE_EXTINT = 3'b111;

  logic [N-1:0]     pin_q, pending, clr;
  logic [ROT_W-1:0] rot;
  logic             found;
  int unsigned      sel;
  logic [EW-1:0]    ent;
  logic [M-1:0]     phys_t, log_t, lp_t, tgt;
  logic [CW-1:0]    lcount;
  logic [ROT_W-1:0] pick, seen;

  always_comb begin
    found = 1'b0;
    sel   = 0;
    for (int i = 0; i < N; i++)
      if (!found && pending[i]) begin
        found = 1'b1;
        sel   = i;
      end
  end

  assign ent = route_tbl[sel*EW +: EW];

  wire [7:0] e_vec   = ent[7:0];
  wire [2:0] e_mode  = ent[10:8];
  wire       e_dm    = ent[11];
  wire       e_pol   = ent[12];
  wire       e_trig  = ent[13];
  wire       e_mask  = ent[14];
  wire [7:0] e_dest  = ent[23:16];

  wire is_lp   = (e_mode == MODE_LOWPRI);
  wire illegal = is_lp && !e_dm;
  wire take    = found && (!msg_valid || msg_ready);
  wire emit    = take && !e_mask && !illegal;

  always_comb begin
    lcount = '0;
    for (int k = 0; k < M; k++) begin
      phys_t[k] = (e_dest == 8'hFF) || (int'(e_dest) == k);
      log_t[k]  = |(ldr_bytes[k*8 +: 8] & e_dest);
      if (log_t[k]) lcount = lcount + CW'(1);
    end
  end

  always_comb begin
    pick = (lcount == '0) ? '0 : rot % ROT_W'(lcount);
    seen = '0;
    lp_t = '0;
    for (int k = 0; k < M; k++)
      if (log_t[k]) begin
        if (seen == pick) lp_t[k] = 1'b1;
        seen = seen + ROT_W'(1);
      end
  end

  assign tgt = !e_dm ? phys_t : (is_lp ? lp_t : log_t);
  assign clr = take ? (N'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= '0;
      pending <= '0;
      rot     <= '0;
    end else begin
      pin_q   <= irq_pins;
      pending <= (pending & ~clr) | (irq_pins & ~pin_q);
      if (emit && is_lp && lcount != '0) rot <= rot + ROT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid    <= 1'b0;
      cfg_error    <= 1'b0;
      msg_dest     <= '0;
      msg_vector   <= '0;
      msg_dmode    <= '0;
      msg_destmode <= 1'b0;
      msg_level    <= 1'b0;
      msg_trigger  <= 1'b0;
      msg_targets  <= '0;
    end else begin
      cfg_error <= take && !e_mask && illegal;
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (emit) begin
        msg_valid    <= 1'b1;
        msg_dest     <= e_dest;
        msg_vector   <= (e_mode == MODE_EXTINT) ? ext_vector : e_vec;
        msg_dmode    <= e_mode;
        msg_destmode <= e_dm;
        msg_level    <= e_pol;
        msg_trigger  <= e_trig;
        msg_targets  <= tgt;
      end
    end
  end
endmodule

module irq_route_resolver_chk #(
  parameter int M = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [7:0]   msg_dest,
  input logic [7:0]   msg_vector,
  input logic [2:0]   msg_dmode,
  input logic         msg_destmode,
  input logic [M-1:0] msg_targets,
  input logic         cfg_error
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_targets) && $stable(msg_vector) && $stable(msg_dest));
  a_r5_lp_single: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_dmode == 3'b001 |-> $countones(msg_targets) <= 1);
  a_r6_lp_logical_only: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_dmode == 3'b001 |-> msg_destmode);
  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_destmode && msg_dest == 8'hFF |-> &msg_targets);
  a_r3_phys_single: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_destmode && msg_dest != 8'hFF |-> $countones(msg_targets) <= 1);
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> !cfg_error);
endmodule

bind irq_route_resolver irq_route_resolver_chk #(.M(M)) u_chk (.*);

// File: tb/test_irq_route_resolver.sv
`timescale 1ns/1ps
module test_irq_route_resolver;
  localparam int N = 8;
  localparam int M = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   irq_pins = '0;
  logic [N*24-1:0] route_tbl = '0;
  logic [M*8-1:0] ldr_bytes = '0;
  logic [7:0]     ext_vector = '0;
  logic           msg_ready = 1'b1;
  logic           msg_valid, msg_destmode, msg_level, msg_trigger, cfg_error;
  logic [7:0]     msg_dest, msg_vector;
  logic [2:0]     msg_dmode;
  logic [M-1:0]   msg_targets;

  int checks = 0, fails = 0, rot_ref = 0;

  irq_route_resolver #(.N(N), .M(M)) i_irq_route_resolver (.*);

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(logic [7:0] dest, bit mask, bit trig, bit pol,
                                     bit dm, logic [2:0] mode, logic [7:0] vec);
    return {dest, 1'b0, mask, trig, pol, dm, mode, vec};
  endfunction

  function automatic logic [M-1:0] ref_targets(logic [23:0] e, logic [M*8-1:0] l, int r);
    logic [M-1:0] t, m;
    int cnt, pk, sn;
    t = '0;
    if (!e[11]) begin
      for (int k = 0; k < M; k++) t[k] = (e[23:16] == 8'hFF) || (int'(e[23:16]) == k);
    end else begin
      for (int k = 0; k < M; k++) m[k] = (l[k*8 +: 8] & e[23:16]) != 0;
      t = m;
      if (e[10:8] == 3'b001) begin
        cnt = $countones(m);
        t = '0;
        if (cnt > 0) begin
          pk = r % cnt;
          sn = 0;
          for (int k = 0; k < M; k++)
            if (m[k]) begin
              if (sn == pk) t[k] = 1'b1;
              sn++;
            end
        end
      end
    end
    return t;
  endfunction

  task automatic wait_evt(output bit got, output bit err);
    got = 0; err = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (cfg_error) err = 1;
      if (msg_valid) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic run_event(input int ln, input logic [23:0] e, input string tag);
    bit got, err, lp, dm;
    logic [M-1:0] et;
    @(negedge clk);
    route_tbl[ln*24 +: 24] = e;
    irq_pins[ln] = 1'b1;
    lp = (e[10:8] == 3'b001);
    dm = e[11];
    et = ref_targets(e, ldr_bytes, rot_ref);
    wait_evt(got, err);
    if (e[14]) begin
      chk(!got && !err, "R2 masked dropped", {got, err}, 0);
    end else if (lp && !dm) begin
      chk(err && !got, "R6 illegal flagged", {got, err}, 1);
    end else begin
      chk(got, {tag, " message emitted"}, got, 1);
      if (got) begin
        chk(msg_targets == et, {tag, " targets"}, msg_targets, et);
        chk(msg_vector == ((e[10:8] == 3'b111) ? ext_vector : e[7:0]), "R7 vector",
            msg_vector, (e[10:8] == 3'b111) ? ext_vector : e[7:0]);
        chk({msg_dest, msg_dmode, msg_destmode, msg_level, msg_trigger} ==
            {e[23:16], e[10:8], e[11], e[12], e[13]}, "R8 fields",
            {msg_dest, msg_dmode, msg_destmode, msg_level, msg_trigger},
            {e[23:16], e[10:8], e[11], e[12], e[13]});
        if (lp && et != '0) rot_ref++;
      end
    end
    @(negedge clk);
    irq_pins[ln] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    bit got, err;
    logic [23:0] e;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(!msg_valid && !cfg_error, "R11 reset state", {msg_valid, cfg_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: held high signals once, re-arm on low
    run_event(2, mk(8'h01, 0, 0, 0, 0, 3'b000, 8'h42), "R1");
    irq_pins[2] = 1'b1;
    wait_evt(got, err);
    chk(got, "R1 first edge", got, 1);
    wait_evt(got, err);
    chk(!got, "R1 held high no resignal", got, 0);
    irq_pins[2] = 1'b0;
    @(negedge clk);
    wait_evt(got, err);
    chk(!got, "R1 lowering no signal", got, 0);
    irq_pins[2] = 1'b1;
    wait_evt(got, err);
    chk(got, "R1 re-raise signals", got, 1);
    @(negedge clk);
    irq_pins[2] = 1'b0;
    @(negedge clk);

    // R3 physical corners
    run_event(0, mk(8'hFF, 0, 1, 1, 0, 3'b000, 8'h11), "R3 broadcast");
    run_event(1, mk(8'h10, 0, 0, 0, 0, 3'b000, 8'h12), "R3 out of range");
    run_event(3, mk(8'h03, 0, 0, 1, 0, 3'b000, 8'h13), "R3 index");
    // R4 logical, R5 rotation and empty match
    ldr_bytes = {8'h01, 8'h00, 8'h01, 8'h01};
    for (int j = 0; j < 5; j++) run_event(4, mk(8'h01, 0, 0, 0, 1, 3'b001, 8'h20), "R5 rotation");
    run_event(5, mk(8'h80, 0, 0, 0, 1, 3'b001, 8'h21), "R5 no match");
    run_event(6, mk(8'h03, 0, 0, 0, 1, 3'b000, 8'h22), "R4 logical");
    run_event(7, mk(8'h02, 0, 0, 0, 0, 3'b001, 8'h23), "R6");
    ext_vector = 8'h9C;
    run_event(1, mk(8'h00, 0, 0, 0, 0, 3'b111, 8'h24), "R7 ext");
    run_event(0, mk(8'h00, 1, 0, 0, 0, 3'b000, 8'h25), "R2");

    // R9/R10: simultaneous edges under stall
    route_tbl[1*24 +: 24] = mk(8'h00, 0, 0, 0, 0, 3'b000, 8'hA1);
    route_tbl[4*24 +: 24] = mk(8'h01, 0, 0, 0, 0, 3'b000, 8'hA4);
    route_tbl[6*24 +: 24] = mk(8'h02, 0, 0, 0, 0, 3'b000, 8'hA6);
    msg_ready = 1'b0;
    irq_pins = 8'b0101_0010;
    wait_evt(got, err);
    chk(got && msg_vector == 8'hA1, "R9 first is lowest line", msg_vector, 8'hA1);
    repeat (3) begin
      @(negedge clk);
      chk(msg_valid && msg_vector == 8'hA1 && msg_targets == 4'b0001, "R10 stall hold",
          msg_vector, 8'hA1);
    end
    msg_ready = 1'b1;
    @(negedge clk);
    chk(msg_valid && msg_vector == 8'hA4, "R9 second line", msg_vector, 8'hA4);
    @(negedge clk);
    chk(msg_valid && msg_vector == 8'hA6, "R9 third line", msg_vector, 8'hA6);
    @(negedge clk);
    chk(!msg_valid, "R9 drained", msg_valid, 0);
    irq_pins = '0;
    @(negedge clk);

    // random stream
    for (int it = 0; it < 300; it++) begin
      logic [2:0] md;
      logic [7:0] ds;
      bit dmr;
      int r;
      r = $urandom % 4;
      md = (r == 1) ? 3'b001 : (r == 2) ? 3'b111 : 3'b000;
      dmr = $urandom % 4 != 0;
      if (!dmr) begin
        r = $urandom % 6;
        ds = (r == 0) ? 8'hFF : (r == 5) ? 8'h10 + 8'($urandom % 16) : 8'(r - 1);
      end else ds = 8'($urandom);
      for (int k = 0; k < M; k++) ldr_bytes[k*8 +: 8] = 8'($urandom) & 8'($urandom);
      ext_vector = 8'($urandom);
      e = mk(ds, ($urandom % 6) == 0, 1'($urandom), 1'($urandom), dmr, md, 8'($urandom));
      run_event($urandom % N, e, "R4/R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule